// File: doc/BRIEF.md
# Three-Phase Half-Bridge Dead-Time Interlock

This block sits between a PWM generator and the gate drivers of a three-phase bridge. Each phase has two commands: a high-side command that is active low and a low-side command that is active high. The block decodes them into two gate-enable outputs per phase, one for the high switch and one for the low switch. Two inputs override everything else: a global shutdown and an undervoltage flag. Either one clears all six enables.

In normal operation the decode gives the low-side command precedence. A phase therefore never requests both of its switches at once. Any enable that was on turns off at the next clock edge. An enable that is being switched on waits a programmable number of clock cycles first. This turn-on delay is the dead time, and it lets the opposite switch finish turning off. All three phases share one dead-time count.

A bypass control removes both the delay and the precedence rule. The enables then follow the commands directly. This suits loads that need both switches of a phase on at the same time. If the high-side commands are held low, each low-side command alone drives its phase complementarily, with dead time inserted at every transition.

Top module: `bridge_deadtime_ctl`

## Requirements
- R1: While `shut_dn` is high at a clock edge, all six enables are low after that edge, whatever the other inputs are.
- R2: While `uv_flag` is high at a clock edge, all six enables are low after that edge.
- R3: With bypass off, a high `ls_cmd[p]` requests the low switch of phase p and withholds the high switch, whatever `hs_cmd_n[p]` is. `ls_on[p]` and `hs_on[p]` are never both high unless bypass was high at the previous edge.
- R4: With bypass off and `ls_cmd[p]` low, `hs_cmd_n[p]`=0 requests the high switch, and `hs_cmd_n[p]`=1 leaves both switches of phase p off.
- R5: An enable falls at the first clock edge at which its request is absent, with no added delay.
- R6: Let an enable's request first be seen at edge k and stay present. Then, with bypass off and dead-time count D, the enable rises after edge k+D. If the request drops before then, the count starts again from zero. Once high, the enable stays high while its request stays present.
- R7: A dead-time count of zero gives a turn-on after the same edge that sees the request. The precedence of R3 still holds.
- R8: With `dt_bypass` high and neither override active, after each edge `ls_on[p]` equals `ls_cmd[p]` and `hs_on[p]` equals the inverse of `hs_cmd_n[p]`, so both enables may be high.
- R9: With all `hs_cmd_n` held low and bypass off, each phase's two enables are complementary in steady state. A dead-time gap of D cycles, with both enables low, separates every hand-over.
- R10: While `rst_n` is low, all six enables are low. Inputs left at their idle level (all commands and `shut_dn` high) keep every enable low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs are synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_cmd_n | input | PHASES | High-side commands, active low, one per phase |
| ls_cmd | input | PHASES | Low-side commands, active high, one per phase |
| shut_dn | input | 1 | Global shutdown, forces all enables low |
| uv_flag | input | 1 | Undervoltage indication, forces all enables low |
| dt_bypass | input | 1 | Removes dead time and precedence when high |
| dt_cycles | input | DW | Dead-time turn-on delay in clock cycles, shared by all phases |
| ls_on | output | PHASES | Low-switch gate enables |
| hs_on | output | PHASES | High-switch gate enables |

## Verification
Every enable is registered. Turn-offs, overrides and bypass-mode changes therefore appear one edge after the inputs that cause them. A turn-on in dead-time mode appears D edges later than that. The bench changes its inputs on the falling clock edge. At that same point it advances a reference model by one edge and samples the enables at the next falling edge, so each comparison lines up with the first cycle in which a result is due. The model counts how many edges each request has been present without interruption. A turn-on is expected only once that count exceeds D. A long count that is interrupted just before the limit is therefore flagged if the design turns on early or late.

// File: rtl/dt_interlock_pkg.sv
package dt_interlock_pkg;

  // Requested switch states of one phase after priority decode.
  typedef struct packed {
    logic lo;
    logic hi;
  } leg_req_t;

  // Priority decode of one phase. kill covers shutdown and undervoltage.
  function automatic leg_req_t steer(input logic lo_cmd,
                                     input logic hi_cmd_n,
                                     input logic kill,
                                     input logic bypass);
    leg_req_t r;
    r.lo = 1'b0;
    r.hi = 1'b0;
    if (!kill) begin
      if (bypass) begin
        r.lo = lo_cmd;
        r.hi = ~hi_cmd_n;
      end else if (lo_cmd) begin
        r.lo = 1'b1;
      end else begin
        r.hi = ~hi_cmd_n;
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/dt_phase_steer.sv
module dt_phase_steer
  import dt_interlock_pkg::*;
(
  input  logic lo_cmd,
  input  logic hi_cmd_n,
  input  logic kill,
  input  logic bypass,
  output logic lo_req,
  output logic hi_req
);

  leg_req_t req;

  always_comb begin
    req    = steer(lo_cmd, hi_cmd_n, kill, bypass);
    lo_req = req.lo;
    hi_req = req.hi;
  end

  // Outside bypass, the decode never asks for both switches.
  always_comb begin
    if (!bypass) begin
      assert_req_exclusive_R3: assert (!(lo_req && hi_req))
        else $error("R3: both legs requested without bypass");
    end
  end

endmodule

// File: rtl/dt_turnon_timer.sv
module dt_turnon_timer #(
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          instant,
  input  logic [DW-1:0] dly,
  output logic          en
);

  logic [DW-1:0] cnt;
  logic          count_done;
  logic          turn_on_evt;

  // Number of edges already seen with the request present covers the delay.
  function automatic logic delay_met(input logic [DW-1:0] seen,
                                     input logic [DW-1:0] limit);
    return seen >= limit;
  endfunction

  assign count_done  = delay_met(cnt, dly);
  assign turn_on_evt = req && !en && (instant || count_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (!req) begin
      en  <= 1'b0;
      cnt <= '0;
    end else if (!en) begin
      if (turn_on_evt) en <= 1'b1;
      else             cnt <= cnt + 1'b1;
    end
  end

  assert_drop_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !en)
    else $error("R5: enable stayed high after request dropped");

  assert_rise_needs_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> $past(req))
    else $error("R6: enable rose without a request");

  assert_hold_while_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && req) |=> en)
    else $error("R6: enable fell while request held");

endmodule

// File: rtl/bridge_deadtime_ctl.sv
module bridge_deadtime_ctl #(
  parameter int PHASES = 3,
  parameter int DW     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hs_cmd_n,
  input  logic [PHASES-1:0] ls_cmd,
  input  logic              shut_dn,
  input  logic              uv_flag,
  input  logic              dt_bypass,
  input  logic [DW-1:0]     dt_cycles,
  output logic [PHASES-1:0] ls_on,
  output logic [PHASES-1:0] hs_on
);

  localparam int LEGS = 2 * PHASES;

  logic              kill_all;
  logic [PHASES-1:0] lo_req;
  logic [PHASES-1:0] hi_req;
  logic [LEGS-1:0]   leg_req;
  logic [LEGS-1:0]   leg_en;

  assign kill_all = shut_dn | uv_flag;
  assign leg_req  = {hi_req, lo_req};
  assign ls_on    = leg_en[PHASES-1:0];
  assign hs_on    = leg_en[LEGS-1:PHASES];

  for (genvar p = 0; p < PHASES; p++) begin : g_phase
    dt_phase_steer u_steer (
      .lo_cmd   (ls_cmd[p]),
      .hi_cmd_n (hs_cmd_n[p]),
      .kill     (kill_all),
      .bypass   (dt_bypass),
      .lo_req   (lo_req[p]),
      .hi_req   (hi_req[p])
    );

    assert_zero_dly_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (dt_cycles == '0 && !dt_bypass && !kill_all && ls_cmd[p]) |=> (ls_on[p] && !hs_on[p]))
      else $error("R7: zero dead time did not turn low leg on at once");
  end

  for (genvar l = 0; l < LEGS; l++) begin : g_leg
    dt_turnon_timer #(.DW(DW)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (leg_req[l]),
      .instant (dt_bypass),
      .dly     (dt_cycles),
      .en      (leg_en[l])
    );
  end

  assert_shutdown_R1: assert property (@(posedge clk) disable iff (!rst_n)
    shut_dn |=> (ls_on == '0 && hs_on == '0))
    else $error("R1: enable high after shutdown");

  assert_undervolt_R2: assert property (@(posedge clk) disable iff (!rst_n)
    uv_flag |=> (ls_on == '0 && hs_on == '0))
    else $error("R2: enable high after undervoltage");

  assert_no_overlap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((ls_on & hs_on) != '0) |-> $past(dt_bypass))
    else $error("R3: both legs of a phase on outside bypass");

  assert_bypass_follow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (dt_bypass && !kill_all) |=> (ls_on == $past(ls_cmd) && hs_on == ~$past(hs_cmd_n)))
    else $error("R8: bypass outputs do not follow commands");

  assert_reset_low_R10: assert property (@(posedge clk)
    !rst_n |-> (ls_on == '0 && hs_on == '0))
    else $error("R10: enable high in reset");

endmodule

// File: tb/sim_bridge_deadtime_ctl.sv
`timescale 1ns/1ps
module sim_bridge_deadtime_ctl;

  localparam int P  = 3;
  localparam int DW = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [P-1:0]  hs_cmd_n = '1;
  logic [P-1:0]  ls_cmd = '1;
  logic          shut_dn = 1'b1;
  logic          uv_flag = 1'b0;
  logic          dt_bypass = 1'b0;
  logic [DW-1:0] dt_cycles = '0;
  logic [P-1:0]  ls_on, hs_on;

  int n_cmp = 0;
  int n_bad = 0;

  // reference state: bits [P-1:0] low legs, [2P-1:P] high legs
  logic [2*P-1:0] exp_en = '0;
  int             run [2*P];

  always #10 clk = ~clk;

  bridge_deadtime_ctl #(.PHASES(P), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .hs_cmd_n(hs_cmd_n), .ls_cmd(ls_cmd),
    .shut_dn(shut_dn), .uv_flag(uv_flag), .dt_bypass(dt_bypass),
    .dt_cycles(dt_cycles), .ls_on(ls_on), .hs_on(hs_on)
  );

  // Wanted legs of one phase as {high, low}, from the requirements.
  function automatic logic [1:0] wanted(input int p);
    logic on_hi, on_lo;
    on_hi = (hs_cmd_n[p] == 1'b0);
    on_lo = ls_cmd[p];
    if (shut_dn || uv_flag) return 2'b00;        // R1, R2
    if (dt_bypass)          return {on_hi, on_lo}; // R8
    if (on_lo)              return 2'b01;        // R3
    return {on_hi, 1'b0};                        // R4
  endfunction

  task automatic model_edge();
    for (int p = 0; p < P; p++) begin
      logic [1:0] w;
      w = wanted(p);
      for (int s = 0; s < 2; s++) begin
        int idx;
        idx = p + s * P;
        if (!w[s]) begin
          run[idx]    = 0;
          exp_en[idx] = 1'b0;
        end else begin
          if (run[idx] < 100000) run[idx]++;
          exp_en[idx] = dt_bypass || exp_en[idx] || (run[idx] > int'(dt_cycles));
        end
      end
    end
  endtask

  task automatic tick(input string tag);
    model_edge();
    @(negedge clk);
    n_cmp++;
    if ({hs_on, ls_on} !== exp_en) begin
      n_bad++;
      $display("FAIL %s: got hs=%b ls=%b expected hs=%b ls=%b at %0t",
               tag, hs_on, ls_on, exp_en[2*P-1:P], exp_en[P-1:0], $time);
    end
  endtask

  task automatic ticks(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  function automatic string classify();
    if (shut_dn)   return "R1";
    if (uv_flag)   return "R2";
    if (dt_bypass) return "R8";
    return "R6";
  endfunction

  initial begin
    #4000000;
    n_bad++;
    $display("FAIL watchdog: got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2*P; i++) run[i] = 0;
    // R10: reset with idle (all-high) inputs
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({hs_on, ls_on} !== '0) begin
      n_bad++;
      $display("FAIL R10: got %b expected 000000", {hs_on, ls_on});
    end
    rst_n = 1'b1;
    ticks(3, "R10");          // idle inputs keep everything off

    // R1 shutdown with otherwise active commands
    hs_cmd_n = '0; ls_cmd = 3'b010; dt_cycles = 12'd3;
    ticks(3, "R1");
    // R9/R6: release shutdown, highs request with dead time 3
    shut_dn = 1'b0;
    ticks(6, "R9");
    // R5/R9: phase 0 hands over to low side
    ls_cmd[0] = 1'b1;
    ticks(6, "R5");
    ls_cmd[0] = 1'b0;
    ticks(6, "R9");
    // R3: low command wins over an active high command
    ls_cmd = '1; hs_cmd_n = '0;
    ticks(5, "R3");
    // R4: both commands idle -> both off; high only when hs_cmd_n low
    ls_cmd = '0; hs_cmd_n = '1;
    ticks(3, "R4");
    hs_cmd_n = 3'b101;
    ticks(5, "R4");
    // R6: restart when request drops before the count expires
    dt_cycles = 12'd5; hs_cmd_n = '1;
    ticks(2, "R6");
    hs_cmd_n = 3'b000; ticks(3, "R6");
    hs_cmd_n = 3'b111; ticks(1, "R6");
    hs_cmd_n = 3'b000; ticks(8, "R6");
    // R7: zero dead time, complementary toggling
    dt_cycles = '0;
    for (int k = 0; k < 6; k++) begin
      ls_cmd = (k % 2 == 0) ? 3'b111 : 3'b000;
      ticks(2, "R7");
    end
    // R8: bypass lets both legs on
    dt_cycles = 12'd4; dt_bypass = 1'b1; ls_cmd = '1; hs_cmd_n = '0;
    ticks(3, "R8");
    hs_cmd_n = 3'b110; ls_cmd = 3'b011;
    ticks(2, "R8");
    // R2: undervoltage clears all
    uv_flag = 1'b1;
    ticks(3, "R2");
    uv_flag = 1'b0; dt_bypass = 1'b0;
    ticks(6, "R6");
    // R1 mid-run
    shut_dn = 1'b1; ticks(2, "R1");
    shut_dn = 1'b0;

    // constrained random segments
    for (int seg = 0; seg < 500; seg++) begin
      int hold;
      hs_cmd_n  = P'($urandom);
      ls_cmd    = P'($urandom);
      shut_dn   = ($urandom % 16) == 0;
      uv_flag   = ($urandom % 16) == 0;
      dt_bypass = ($urandom % 8) == 0;
      if (($urandom % 8) == 0) dt_cycles = DW'($urandom % 7);
      hold = 1 + ($urandom % 10);
      ticks(hold, classify());
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule